// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is a down-counting timer that asks the local interrupt acceptance logic for service each time its count runs out. One packed 32-bit configuration word controls how it behaves on expiry. That word holds the vector to deliver, a delivery mode, a trigger-mode bit, a mask bit and a bit that selects periodic or one-shot operation. Software starts a countdown by writing a start value. The counter then moves down by one on each cycle in which the `tick` input is high. When the count goes from one to zero, that cycle is the expiry.

On expiry the block sends a one-cycle request pulse carrying the vector, the delivery mode and the trigger bit, unless the mask bit is set. In periodic operation the counter then reloads from the stored start value, whether or not the request was masked. In one-shot operation the counter stays at zero. Writing a start value of zero stops the timer. The live count can be read back but cannot be written. A clock divider and bus address decoding are outside the block.

Register selects on `reg_addr`: 0 is the configuration word, 1 is the start value, 2 is the live count (read-only), and 3 is reserved.

Top module: `lvt_timer`

## Requirements
- R1: After reset the configuration word reads 0x0001_0000 (masked, all other fields zero), and both the start value and the live count read 0. `irq_valid` is low.
- R2: Configuration word layout:
  - vector: bits 7:0
  - delivery mode: bits 10:8
  - polarity: bit 13
  - trigger mode: bit 15
  - mask: bit 16
  - periodic: bit 17

  Only these bits are stored. A read returns the written value ANDed with 0x0003_A7FF, so bits 11, 12, 14 and 31:18 read as zero.
- R3: A write to select 1 stores the start value and loads it into the counter. From the next cycle the live count (select 2) and the start value (select 1) both read the written value.
- R4: While the count is above zero, each cycle with `tick` high lowers it by one. A cycle with `tick` low and no start-value write leaves it unchanged.
- R5: A `tick` with count equal to one is an expiry. If mask bit 16 is clear, the expiry sets `irq_valid` high for exactly the next cycle. In that cycle `irq_vector` equals bits 7:0, `irq_mode` equals bits 10:8 and `irq_level` equals bit 15 of the configuration word as it stood in the expiry cycle.
- R6: With mask bit 16 set, an expiry raises no request. The counter still reloads or stops exactly as it would if unmasked.
- R7: With periodic bit 17 clear, the count reads 0 after expiry and stays at 0, with no further requests, until a new start value is written.
- R8: With periodic bit 17 set, expiry reloads the counter from the start value. A start value N gives an expiry every N ticks.
- R9: Writing a start value of 0 stops the counter at 0, and no request follows.
- R10: A start-value write in the same cycle as a `tick` takes priority. The counter loads the written value, and no expiry occurs in that cycle.
- R11: Writes to select 2 (live count) and select 3 (reserved) are ignored, and the count is unchanged.
- R12: Reading select 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable; one decrement per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 config, 1 start value, 2 live count, 3 reserved) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| irq_valid | output | 1 | One-cycle request pulse |
| irq_vector | output | 8 | Vector of the request |
| irq_mode | output | 3 | Delivery mode of the request |
| irq_level | output | 1 | Trigger-mode bit of the request |

## Verification
The checker watches the counter every cycle. It confirms that the count steps down by one per tick, holds when idle, loads on a start-value write, and either clears or reloads on expiry according to the periodic bit. It also confirms that a request follows exactly those expiries that were unmasked. The bench scenarios are needed for the things the per-cycle checks cannot see:
- the contents of the request fields and the layout of the configuration word;
- the spacing of expiries over whole periods, with and without idle cycles between ticks;
- the write-versus-tick priority, and the ignored writes to the count and reserved selects.

// File: rtl/lvt_timer_pkg.sv
// Package: field positions of the timer configuration word and register
// selects shared by the timer, its submodules, checker and bench.
package lvt_timer_pkg;

    localparam int CFG_W      = 32;
    localparam int SEL_W      = 2;
    localparam int VEC_LSB    = 0;
    localparam int VEC_W      = 8;
    localparam int MODE_LSB   = 8;
    localparam int MODE_W     = 3;
    localparam int POL_BIT    = 13;
    localparam int TRIG_BIT   = 15;
    localparam int MASK_BIT   = 16;
    localparam int PER_BIT    = 17;

    // Bits that hold state; every other bit reads back as zero.
    localparam logic [CFG_W-1:0] CFG_KEEP =
        (((CFG_W)'(1) << VEC_W) - 1) << VEC_LSB |
        (((CFG_W)'(1) << MODE_W) - 1) << MODE_LSB |
        (CFG_W)'(1) << POL_BIT |
        (CFG_W)'(1) << TRIG_BIT |
        (CFG_W)'(1) << MASK_BIT |
        (CFG_W)'(1) << PER_BIT;

    localparam logic [CFG_W-1:0] CFG_RESET = (CFG_W)'(1) << MASK_BIT;

    typedef enum logic [SEL_W-1:0] {
        SEL_CFG   = 2'd0,
        SEL_START = 2'd1,
        SEL_LIVE  = 2'd2,
        SEL_RSVD  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/lvt_timer_regs.sv
// lvt_timer_regs: holds the configuration word and the start value,
// decodes writes, and muxes read data. Assumes CNT_W <= CFG_W; the live
// count is supplied by the counter and is never written here.
module lvt_timer_regs
    import lvt_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] sel,
    input  logic [CFG_W-1:0] wdata,
    input  logic [CNT_W-1:0] live_count,
    output logic [CFG_W-1:0] rdata,
    output logic [CNT_W-1:0] start_q,
    output logic             start_wr,
    output logic [VEC_W-1:0] f_vector,
    output logic [MODE_W-1:0] f_mode,
    output logic             f_level,
    output logic             f_mask,
    output logic             f_periodic
);

    logic [CFG_W-1:0] cfg_q;
    logic [CFG_W-1:0] start_ext;
    logic [CFG_W-1:0] live_ext;

    // Decode a write to the start-value select.
    assign start_wr = wr_en && (sel == SEL_START);

    // Configuration word storage; only kept bits take the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (wr_en && (sel == SEL_CFG)) begin
            cfg_q <= wdata & CFG_KEEP;
        end
    end

    // Start value storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
        end else if (start_wr) begin
            start_q <= wdata[CNT_W-1:0];
        end
    end

    // Zero-extend counter-width values onto the register width.
    generate
        if (CNT_W == CFG_W) begin : g_full
            assign start_ext = start_q;
            assign live_ext  = live_count;
        end else begin : g_ext
            assign start_ext = {{(CFG_W-CNT_W){1'b0}}, start_q};
            assign live_ext  = {{(CFG_W-CNT_W){1'b0}}, live_count};
        end
    endgenerate

    // Read mux over the four selects.
    always_comb begin
        case (sel)
            SEL_CFG:   rdata = cfg_q;
            SEL_START: rdata = start_ext;
            SEL_LIVE:  rdata = live_ext;
            default:   rdata = '0;
        endcase
    end

    // Field extraction for the counter and the request stage.
    assign f_vector   = cfg_q[VEC_LSB +: VEC_W];
    assign f_mode     = cfg_q[MODE_LSB +: MODE_W];
    assign f_level    = cfg_q[TRIG_BIT];
    assign f_mask     = cfg_q[MASK_BIT];
    assign f_periodic = cfg_q[PER_BIT];

endmodule

// File: rtl/lvt_timer_counter.sv
// lvt_timer_counter: the down counter. A load has priority over counting;
// a tick at count one is the expiry, after which the counter reloads
// (periodic) or parks at zero. A count of zero is idle.
module lvt_timer_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             periodic,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Expiry: a tick on the last count, not overridden by a load.
    assign expire = tick && !load && (count == ONE);

    // Count state: load, expiry handling, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (expire) begin
            count <= periodic ? reload_val : '0;
        end else if (tick && (count != '0)) begin
            count <= count - ONE;
        end
    end

endmodule

// File: rtl/lvt_timer_request.sv
// lvt_timer_request: turns an unmasked expiry into a registered one-cycle
// request. The fields are captured from the configuration word in force
// during the expiry cycle and are meaningful only while valid is high.
module lvt_timer_request
    import lvt_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              expire,
    input  logic              mask,
    input  logic [VEC_W-1:0]  vector_in,
    input  logic [MODE_W-1:0] mode_in,
    input  logic              level_in,
    output logic              valid,
    output logic [VEC_W-1:0]  vector,
    output logic [MODE_W-1:0] mode,
    output logic              level
);

    logic fire;

    assign fire = expire && !mask;

    // Request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) valid <= 1'b0;
        else        valid <= fire;
    end

    // Capture the request fields on each unmasked expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vector <= '0;
            mode   <= '0;
            level  <= 1'b0;
        end else if (fire) begin
            vector <= vector_in;
            mode   <= mode_in;
            level  <= level_in;
        end
    end

endmodule

// File: rtl/lvt_timer.sv
// lvt_timer: local interrupt countdown timer. It connects the register
// file, the down counter and the request stage. Assumes tick is
// synchronous to clk and that CNT_W does not exceed the register width.
module lvt_timer
    import lvt_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq_valid,
    output logic [7:0]  irq_vector,
    output logic [2:0]  irq_mode,
    output logic        irq_level
);

    logic [CNT_W-1:0]  cur_count;
    logic [CNT_W-1:0]  start_q;
    logic              start_wr;
    logic [VEC_W-1:0]  cfg_vector;
    logic [MODE_W-1:0] cfg_mode;
    logic              cfg_level;
    logic              cfg_mask;
    logic              cfg_periodic;
    logic              expire;

    lvt_timer_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .sel        (reg_addr),
        .wdata      (reg_wdata),
        .live_count (cur_count),
        .rdata      (reg_rdata),
        .start_q    (start_q),
        .start_wr   (start_wr),
        .f_vector   (cfg_vector),
        .f_mode     (cfg_mode),
        .f_level    (cfg_level),
        .f_mask     (cfg_mask),
        .f_periodic (cfg_periodic)
    );

    lvt_timer_counter #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load       (start_wr),
        .load_val   (reg_wdata[CNT_W-1:0]),
        .periodic   (cfg_periodic),
        .reload_val (start_q),
        .count      (cur_count),
        .expire     (expire)
    );

    lvt_timer_request u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire    (expire),
        .mask      (cfg_mask),
        .vector_in (cfg_vector),
        .mode_in   (cfg_mode),
        .level_in  (cfg_level),
        .valid     (irq_valid),
        .vector    (irq_vector),
        .mode      (irq_mode),
        .level     (irq_level)
    );

endmodule

// File: rtl/lvt_timer_chk.sv
// lvt_timer_chk: cycle-by-cycle properties of the timer, bound to every
// lvt_timer instance.
module lvt_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             load,
    input logic             periodic,
    input logic             mask,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] start_q,
    input logic             expire,
    input logic             irq_valid
);

    // R3: a start-value write appears in the count on the next cycle
    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == start_q));

    // R4: a tick above one lowers the count by one
    a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && (count > CNT_W'(1))) |=> (count == $past(count) - CNT_W'(1)));

    // R4: no tick and no write hold the count
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(count));

    // R5: an unmasked expiry yields a request on the next cycle
    a_r5_request: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !mask) |=> irq_valid);

    // R6: no request without an unmasked expiry
    a_r6_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !(expire && !mask) |=> !irq_valid);

    // R7: one-shot expiry parks the counter at zero
    a_r7_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !periodic) |=> (count == '0));

    // R8: periodic expiry reloads the start value
    a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && periodic) |=> (count == $past(start_q)));

    // R9: an idle counter never expires
    a_r9_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !expire);

endmodule

bind lvt_timer lvt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .load      (start_wr),
    .periodic  (cfg_periodic),
    .mask      (cfg_mask),
    .count     (cur_count),
    .start_q   (start_q),
    .expire    (expire),
    .irq_valid (irq_valid)
);

// File: tb/lvt_timer_test.sv
// Bench for lvt_timer: sweeps start values, mask/periodic settings and
// tick patterns against an arithmetic model of the requirements.
module lvt_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd2;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_valid;
    logic [7:0]  irq_vector;
    logic [2:0]  irq_mode;
    logic        irq_level;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Model state
    logic [31:0] m_cnt = '0;
    logic [31:0] m_start = '0;
    logic [31:0] m_cfg = 32'h0001_0000;

    always #5 clk = ~clk;

    lvt_timer uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_mode(irq_mode),
        .irq_level(irq_level)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        tick = 1'b0; reg_wr = 1'b0; reg_addr = a;
        #1 v = reg_rdata;
    endtask

    // One clock: drive, advance model, then check request and live count.
    task automatic cyc(input logic t, input logic w, input logic [1:0] a,
                       input logic [31:0] d, input string tag);
        logic e, ev;
        logic [7:0] ex_vec;
        logic [2:0] ex_mode;
        logic ex_lvl;
        @(negedge clk);
        tick = t; reg_wr = w; reg_addr = a; reg_wdata = d;
        e = t && !(w && a == 2'd1) && (m_cnt == 32'd1);
        ev = e && !m_cfg[16];
        ex_vec = m_cfg[7:0]; ex_mode = m_cfg[10:8]; ex_lvl = m_cfg[15];
        if (w && a == 2'd1) begin
            m_start = d; m_cnt = d;
        end else if (e) begin
            m_cnt = m_cfg[17] ? m_start : 32'd0;
        end else if (t && m_cnt != 0) begin
            m_cnt = m_cnt - 1;
        end
        if (w && a == 2'd0) m_cfg = d & 32'h0003_A7FF;
        @(posedge clk);
        #1;
        chk({tag, " irq_valid"}, {31'd0, irq_valid}, {31'd0, ev});
        if (ev) begin
            chk({tag, " vector"}, {24'd0, irq_vector}, {24'd0, ex_vec});
            chk({tag, " mode"}, {29'd0, irq_mode}, {29'd0, ex_mode});
            chk({tag, " level"}, {31'd0, irq_level}, {31'd0, ex_lvl});
        end
        tick = 1'b0; reg_wr = 1'b0; reg_addr = 2'd2;
        #1 chk({tag, " R4 count"}, reg_rdata, m_cnt);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        #1 chk("R1 irq_valid", {31'd0, irq_valid}, 32'd0);
        rd(2'd0, v); chk("R1 cfg", v, 32'h0001_0000);
        rd(2'd1, v); chk("R1 start", v, 32'd0);
        rd(2'd2, v); chk("R1 count", v, 32'd0);

        // R2: field storage mask
        cyc(1'b0, 1'b1, 2'd0, 32'hFFFF_FFFF, "R2");
        rd(2'd0, v); chk("R2 all ones", v, 32'h0003_A7FF);
        cyc(1'b0, 1'b1, 2'd0, 32'h0000_0000, "R2");
        rd(2'd0, v); chk("R2 zero", v, 32'd0);

        // Sweep over start value, mask/periodic and tick pattern (R3 R5-R8)
        for (int n = 1; n <= 5; n++) begin
            for (int cfg = 0; cfg < 4; cfg++) begin
                for (int gap = 0; gap < 2; gap++) begin
                    logic [31:0] word;
                    string tag;
                    word = (32'(cfg & 1) << 16) | (32'(cfg >> 1) << 17) |
                           (32'(n & 1) << 15) | (32'(gap) << 13) |
                           (32'((n + cfg) % 8) << 8) | 32'((8'h30 + n * 11 + cfg * 3) & 8'hFF);
                    tag = $sformatf("%s %s n=%0d", (cfg & 1) ? "R6" : "R5",
                                    (cfg >> 1) ? "R8" : "R7", n);
                    cyc(1'b0, 1'b1, 2'd0, word, "R2 cfg");
                    rd(2'd0, v); chk("R2 readback", v, word & 32'h0003_A7FF);
                    cyc(1'b0, 1'b1, 2'd1, 32'(n), "R3 load");
                    rd(2'd1, v); chk("R3 start", v, 32'(n));
                    for (int k = 0; k < 3 * n + 2; k++) begin
                        cyc(gap ? (k % 3 != 2) : 1'b1, 1'b0, 2'd2, 32'd0, tag);
                    end
                end
            end
        end

        // R9: zero start value stops the timer
        cyc(1'b0, 1'b1, 2'd0, 32'h0002_0041, "R9 cfg");
        cyc(1'b0, 1'b1, 2'd1, 32'd5, "R9 load");
        cyc(1'b1, 1'b0, 2'd2, 32'd0, "R9");
        cyc(1'b1, 1'b0, 2'd2, 32'd0, "R9");
        cyc(1'b0, 1'b1, 2'd1, 32'd0, "R9 stop");
        for (int k = 0; k < 10; k++) cyc(1'b1, 1'b0, 2'd2, 32'd0, "R9 idle");

        // R10: write beats a tick at count one
        cyc(1'b0, 1'b1, 2'd0, 32'h0002_8352, "R10 cfg");
        cyc(1'b0, 1'b1, 2'd1, 32'd1, "R10 load");
        cyc(1'b1, 1'b1, 2'd1, 32'd4, "R10 collide");
        for (int k = 0; k < 4; k++) cyc(1'b1, 1'b0, 2'd2, 32'd0, "R10 run");

        // R11: writes to live and reserved selects ignored
        cyc(1'b1, 1'b0, 2'd2, 32'd0, "R11 pre");
        cyc(1'b0, 1'b1, 2'd2, 32'h0000_0055, "R11 live");
        cyc(1'b0, 1'b1, 2'd3, 32'h0000_0077, "R11 rsvd");
        rd(2'd0, v); chk("R11 cfg kept", v, 32'h0002_8352);

        // R12: reserved select reads zero
        rd(2'd3, v); chk("R12 rsvd", v, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule